// File: doc/BRIEF.md
# Parallel Camera Capture Interface

This block receives video from an image sensor that drives a parallel data bus together with a pixel clock, a line sync and a frame sync. All of these signals are asynchronous to the system clock, so the block resynchronizes them and then oversamples them. It keeps only the data words that arrive outside horizontal and vertical blanking and belong to a frame chosen for capture. It packs those words little-endian into 32-bit words and delivers them on a valid/ready stream. The last, partly filled word of a frame carries a marker.

Each frame produces one-cycle pulses at its start and its end. A captured frame also raises a one-cycle completion interrupt when it ends. The following settings are inputs, and they are taken into use only when a frame starts:

- the number of data lines in use;
- the level of each sync signal that marks blanking;
- the pixel clock edge on which data is sampled;
- the frame decimation rate.

When a finished word cannot be handed downstream, it is lost, and this loss is latched in a sticky overflow flag.

Top module: `cam_parallel_rx`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, out_valid, out_last, frame_start, frame_end, overflow and frame_done_irq are 0.
- R2: cfg_bus_width selects the number of data lines in use: code 0 = 8, code 1 = 10, code 2 = 12, code 3 = 14. Lines above the selected count read as zero. With 8 lines, four samples form one word, and the first sample sits in bits 7:0. With more lines, each sample is zero-extended to 16 bits, two samples form one word, and the first sample sits in bits 15:0.
- R3: cfg_hs_pol is the cam_hsync level that means horizontal blanking. Data that arrives while cam_hsync is at that level never appears in the output.
- R4: cfg_vs_pol is the cam_vsync level that means vertical blanking. A frame starts when cam_vsync leaves that level, after the level has been seen, and it ends when cam_vsync returns to it. frame_start and frame_end each pulse for one cycle, for every frame, whether the frame is captured or skipped.
- R5: cfg_pclk_rise = 1 samples data on the rising pixel clock edge, and 0 samples it on the falling edge. The pixel clock period must be at least four system clock periods.
- R6: cfg_rate selects which frames are captured: 0 captures every frame, 1 captures every second frame, 2 captures one frame in four, and 3 behaves as 0. A modulo-4 counter advances at every frame start. The first frame after reset is always captured.
- R7: A setting changed while a frame is in progress has no effect on that frame. It applies from the next frame start.
- R8: If a captured frame ends with a partly filled word, that word is emitted with zeros in its unused slots and with out_last = 1. A frame that ends exactly on a word boundary emits no extra word and no out_last.
- R9: A presented word keeps out_valid and out_data stable until out_ready is seen. If another word completes while a word is still waiting, the new word is discarded and overflow is set. Overflow stays set until reset.
- R10: frame_done_irq pulses for exactly one cycle when a captured frame ends, and it stays 0 when a skipped frame ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_bus_width | input | 2 | Data line count code (0=8, 1=10, 2=12, 3=14) |
| cfg_hs_pol | input | 1 | cam_hsync level that means blanking |
| cfg_vs_pol | input | 1 | cam_vsync level that means blanking |
| cfg_pclk_rise | input | 1 | 1 = sample on rising pixel clock edge, 0 = falling |
| cfg_rate | input | 2 | Frame decimation (0 all, 1 every second, 2 one in four) |
| cam_pclk | input | 1 | Sensor pixel clock |
| cam_hsync | input | 1 | Sensor line sync |
| cam_vsync | input | 1 | Sensor frame sync |
| cam_data | input | DATA_W | Sensor data bus |
| out_data | output | OUT_W | Packed output word |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the word |
| out_last | output | 1 | Word is the padded final word of a frame |
| frame_start | output | 1 | One-cycle pulse at every frame start |
| frame_end | output | 1 | One-cycle pulse at every frame end |
| overflow | output | 1 | Sticky flag: a word was discarded |
| frame_done_irq | output | 1 | One-cycle pulse when a captured frame ends |

## Verification
The overflow path is the hardest to reach from the ports. To reach it, one word must be left waiting while the sensor completes another word. The stimulus holds out_ready low for a whole frame of twelve 8-bit samples, which completes three words against a single output register. The bench then checks that the first word is still presented unchanged and that overflow is set. A second hard case is a width change in the middle of a frame. The stimulus rewrites cfg_bus_width after the first line and expects the whole frame to stay packed at the old width, with the new width applying to the frame that follows.

// File: rtl/cam_parallel_rx.sv
module cam_parallel_rx #(
  parameter int DATA_W      = 14,
  parameter int OUT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_bus_width,
  input  logic              cfg_hs_pol,
  input  logic              cfg_vs_pol,
  input  logic              cfg_pclk_rise,
  input  logic [1:0]        cfg_rate,
  input  logic              cam_pclk,
  input  logic              cam_hsync,
  input  logic              cam_vsync,
  input  logic [DATA_W-1:0] cam_data,
  output logic [OUT_W-1:0]  out_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_last,
  output logic              frame_start,
  output logic              frame_end,
  output logic              overflow,
  output logic              frame_done_irq
);
  localparam int IN_W     = DATA_W + 3;
  localparam int NARROW_N = OUT_W / 8;
  localparam int WIDE_N   = OUT_W / 16;
  localparam int CNT_W    = $clog2(NARROW_N);

  function automatic logic [15:0] width_mask(input logic [1:0] code);
    return 16'((32'd1 << (8 + 2 * code)) - 32'd1);
  endfunction

  logic [SYNC_STAGES-1:0][IN_W-1:0] sync_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], {cam_pclk, cam_hsync, cam_vsync, cam_data}};

  logic [IN_W-1:0]   s_now;
  logic              pk, hs, vs;
  logic [DATA_W-1:0] pd;
  assign s_now = sync_q[SYNC_STAGES-1];
  assign pk    = s_now[IN_W-1];
  assign hs    = s_now[IN_W-2];
  assign vs    = s_now[IN_W-3];
  assign pd    = s_now[DATA_W-1:0];

  logic       pk_d, in_frame, armed, keep;
  logic [1:0] fcnt;
  logic [1:0] sh_width, sh_rate;
  logic       sh_hpol, sh_vpol, sh_rise;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sh_width <= 2'd0;
      sh_rate  <= 2'd0;
      sh_hpol  <= 1'b0;
      sh_vpol  <= 1'b0;
      sh_rise  <= 1'b1;
    end else if (!in_frame) begin
      sh_width <= cfg_bus_width;
      sh_rate  <= cfg_rate;
      sh_hpol  <= cfg_hs_pol;
      sh_vpol  <= cfg_vs_pol;
      sh_rise  <= cfg_pclk_rise;
    end

  logic vs_blank, hs_blank, pix_edge, vpol_ok, start_now, end_now, take, keep_now;
  assign vs_blank  = (vs == sh_vpol);
  assign hs_blank  = (hs == sh_hpol);
  assign pix_edge  = sh_rise ? (pk & ~pk_d) : (~pk & pk_d);
  assign vpol_ok   = (sh_vpol == cfg_vs_pol);
  assign start_now = ~in_frame & armed & vpol_ok & ~vs_blank;
  assign end_now   = in_frame & vs_blank;
  assign take      = in_frame & keep & ~vs_blank & ~hs_blank & pix_edge;

  always_comb
    case (sh_rate)
      2'd1:    keep_now = ~fcnt[0];
      2'd2:    keep_now = (fcnt == 2'd0);
      default: keep_now = 1'b1;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pk_d     <= 1'b0;
      in_frame <= 1'b0;
      armed    <= 1'b0;
      keep     <= 1'b0;
      fcnt     <= 2'd0;
    end else begin
      pk_d <= pk;
      if (start_now) begin
        in_frame <= 1'b1;
        armed    <= 1'b0;
        keep     <= keep_now;
        fcnt     <= fcnt + 2'd1;
      end else begin
        if (end_now) in_frame <= 1'b0;
        if (!in_frame) armed <= vpol_ok & (armed | vs_blank);
      end
    end

  logic [15:0]        smp;
  logic               wide, done, flush, push, busy;
  logic [CNT_W-1:0]   cnt, last_slot;
  logic [CNT_W+3:0]   sh_amt;
  logic [OUT_W-1:0]   acc, word, push_word;
  assign smp       = 16'(pd) & width_mask(sh_width);
  assign wide      = (sh_width != 2'd0);
  assign last_slot = wide ? CNT_W'(WIDE_N - 1) : CNT_W'(NARROW_N - 1);
  assign sh_amt    = wide ? {cnt, 4'b0} : {1'b0, cnt, 3'b0};
  assign word      = acc | (OUT_W'(smp) << sh_amt);
  assign done      = take & (cnt == last_slot);
  assign flush     = end_now & (cnt != '0);
  assign push      = done | flush;
  assign push_word = flush ? acc : word;
  assign busy      = out_valid & ~out_ready;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      acc <= '0;
      cnt <= '0;
    end else if (start_now || flush || done) begin
      acc <= '0;
      cnt <= '0;
    end else if (take) begin
      acc <= word;
      cnt <= cnt + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_data  <= '0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      if (push && !busy) begin
        out_data  <= push_word;
        out_valid <= 1'b1;
        out_last  <= flush;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
      if (push && busy) overflow <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      frame_start    <= 1'b0;
      frame_end      <= 1'b0;
      frame_done_irq <= 1'b0;
    end else begin
      frame_start    <= start_now;
      frame_end      <= end_now;
      frame_done_irq <= end_now & keep;
    end

  p_valid_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));
  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  p_irq_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_irq |=> !frame_done_irq);
  p_start_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);
  p_cfg_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_frame |=> $stable({sh_width, sh_rate, sh_hpol, sh_vpol, sh_rise}));
endmodule

// File: tb/sim_cam_parallel_rx.sv
module sim_cam_parallel_rx;
  localparam int DW = 14;
  localparam int OW = 32;
  localparam int NV = 6;
  // fields: width[15:14] hpol[13] vpol[12] rise[11] rate[10:9] lines[8:5] ppl[4:0]
  localparam logic [15:0] VEC [0:NV-1] = '{
    {2'd0, 1'b0, 1'b0, 1'b1, 2'd0, 4'd2, 5'd8},
    {2'd1, 1'b1, 1'b1, 1'b0, 2'd0, 4'd3, 5'd5},
    {2'd2, 1'b0, 1'b1, 1'b1, 2'd1, 4'd2, 5'd6},
    {2'd3, 1'b1, 1'b0, 1'b0, 2'd2, 4'd3, 5'd3},
    {2'd0, 1'b1, 1'b1, 1'b1, 2'd0, 4'd1, 5'd5},
    {2'd0, 1'b0, 1'b0, 1'b0, 2'd1, 4'd2, 5'd4}
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n = 1'b0;
  logic [1:0]    cfg_bus_width = 2'd0, cfg_rate = 2'd0;
  logic          cfg_hs_pol = 1'b0, cfg_vs_pol = 1'b0, cfg_pclk_rise = 1'b1;
  logic          cam_pclk = 1'b1, cam_hsync = 1'b0, cam_vsync = 1'b0;
  logic [DW-1:0] cam_data = '0;
  logic [OW-1:0] out_data;
  logic          out_valid, out_ready = 1'b1, out_last;
  logic          frame_start, frame_end, overflow, frame_done_irq;

  cam_parallel_rx #(.DATA_W(DW), .OUT_W(OW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_bus_width(cfg_bus_width), .cfg_hs_pol(cfg_hs_pol),
    .cfg_vs_pol(cfg_vs_pol), .cfg_pclk_rise(cfg_pclk_rise), .cfg_rate(cfg_rate),
    .cam_pclk(cam_pclk), .cam_hsync(cam_hsync), .cam_vsync(cam_vsync), .cam_data(cam_data),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready), .out_last(out_last),
    .frame_start(frame_start), .frame_end(frame_end), .overflow(overflow),
    .frame_done_irq(frame_done_irq));

  int n_chk = 0, n_fail = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  logic [31:0] exp_d [0:255];
  bit          exp_l [0:255];
  int wr = 0, rd = 0;
  bit mon_en = 1;
  int fs_n = 0, fe_n = 0, irq_n = 0;

  always @(negedge clk) if (rst_n) begin
    if (frame_start) fs_n++;
    if (frame_end) fe_n++;
    if (frame_done_irq) irq_n++;
    if (mon_en && out_valid && out_ready) begin
      if (rd >= wr) chk(1'b0, "R2 unexpected word", out_data, 32'h0);
      else begin
        chk(out_data == exp_d[rd], "R2 packed word", out_data, exp_d[rd]);
        chk(out_last == exp_l[rd], "R8 last flag", 32'(out_last), 32'(exp_l[rd]));
        rd++;
      end
    end
  end

  // bench model
  logic [1:0]  cur_w;
  bit          cur_h, cur_v, cur_r;
  logic [1:0]  cur_rate;
  int          bfc, m_n, px_seq = 0, kept_n;
  logic [31:0] m_acc;

  task automatic m_push(input bit last);
    exp_d[wr] = m_acc;
    exp_l[wr] = last;
    wr++;
    m_acc = '0;
    m_n = 0;
  endtask

  task automatic m_sample(input logic [1:0] w, input logic [DW-1:0] raw);
    logic [31:0] s;
    s = 32'(raw) & ((32'd1 << (8 + 2 * int'(w))) - 32'd1);
    if (w == 2'd0) begin
      m_acc = m_acc | (s << (8 * m_n));
      m_n++;
      if (m_n == 4) m_push(1'b0);
    end else begin
      m_acc = m_acc | (s << (16 * m_n));
      m_n++;
      if (m_n == 2) m_push(1'b0);
    end
  endtask

  task automatic pc(input logic [DW-1:0] d, input bit hb, input bit vb);
    @(posedge clk); #1 cam_pclk = ~cur_r;
    repeat (2) @(posedge clk);
    #1;
    cam_data  = d;
    cam_hsync = hb ? cur_h : ~cur_h;
    cam_vsync = vb ? cur_v : ~cur_v;
    repeat (2) @(posedge clk);
    #1 cam_pclk = cur_r;
    repeat (3) @(posedge clk);
  endtask

  task automatic set_cfg(input logic [1:0] w, input bit h, input bit v, input bit r, input logic [1:0] rate);
    cur_w = w; cur_h = h; cur_v = v; cur_r = r; cur_rate = rate;
    cfg_bus_width = w; cfg_hs_pol = h; cfg_vs_pol = v; cfg_pclk_rise = r; cfg_rate = rate;
  endtask

  task automatic do_reset();
    cam_pclk = cur_r; cam_vsync = cur_v; cam_hsync = cur_h;
    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    wr = 0; rd = 0; fs_n = 0; fe_n = 0; irq_n = 0; bfc = 0; kept_n = 0;
    repeat (6) @(posedge clk);
  endtask

  task automatic send_frame(input int lines, input int ppl, input bit chg, input logic [1:0] nw);
    bit kept;
    logic [1:0] fw;
    logic [DW-1:0] raw;
    kept = (cfg_rate == 2'd1) ? (bfc % 2 == 0) : (cfg_rate == 2'd2) ? (bfc == 0) : 1'b1;
    bfc = (bfc + 1) % 4;
    if (kept) kept_n++;
    fw = cfg_bus_width;
    m_acc = '0; m_n = 0;
    repeat (3) pc(14'h1555, 1'b1, 1'b1);
    for (int l = 0; l < lines; l++) begin
      repeat (2) pc(14'h2aaa, 1'b1, 1'b0);
      for (int p = 0; p < ppl; p++) begin
        raw = DW'(px_seq * 97 + 13);
        px_seq++;
        pc(raw, 1'b0, 1'b0);
        if (kept) m_sample(fw, raw);
      end
      if (chg && l == 0) cfg_bus_width = nw;
    end
    pc(14'h0f0f, 1'b1, 1'b0);
    if (kept && m_n > 0) m_push(1'b1);
    repeat (3) pc(14'h3333, 1'b1, 1'b1);
    repeat (16) @(posedge clk);
  endtask

  task automatic finish_up();
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 32'h0, 32'h1);
    finish_up();
  end

  initial begin
    set_cfg(2'd0, 1'b0, 1'b0, 1'b1, 2'd0);
    repeat (3) @(posedge clk);
    #1;
    chk(out_valid == 1'b0 && out_last == 1'b0, "R1 out_valid/out_last in reset",
        {30'd0, out_valid, out_last}, 32'h0);
    do_reset();
    chk(out_valid == 1'b0, "R1 out_valid after reset", 32'(out_valid), 32'h0);
    chk(overflow == 1'b0 && frame_done_irq == 1'b0, "R1 overflow/irq after reset",
        {30'd0, overflow, frame_done_irq}, 32'h0);
    chk(frame_start == 1'b0 && frame_end == 1'b0, "R1 frame pulses after reset",
        {30'd0, frame_start, frame_end}, 32'h0);

    // vector table: R2 R3 R4 R5 R6 R8 R10
    for (int i = 0; i < NV; i++) begin
      logic [15:0] v;
      v = VEC[i];
      set_cfg(v[15:14], v[13], v[12], v[11], v[10:9]);
      do_reset();
      for (int f = 0; f < 4; f++) send_frame(int'(v[8:5]), int'(v[4:0]), 1'b0, 2'd0);
      chk(rd == wr, "R2 all words delivered", rd, wr);
      chk(fs_n == 4, "R4 frame_start count", fs_n, 4);
      chk(fe_n == 4, "R4 frame_end count", fe_n, 4);
      chk(irq_n == kept_n, "R6 R10 captured frame count", irq_n, kept_n);
    end

    // R7: mid-frame width change
    set_cfg(2'd0, 1'b0, 1'b0, 1'b1, 2'd0);
    do_reset();
    send_frame(2, 6, 1'b1, 2'd2);
    chk(rd == wr, "R7 old width kept for running frame", rd, wr);
    send_frame(2, 6, 1'b0, 2'd0);
    chk(rd == wr, "R7 new width on next frame", rd, wr);

    // R9: overflow with ready held low
    set_cfg(2'd0, 1'b0, 1'b0, 1'b1, 2'd0);
    do_reset();
    mon_en = 0;
    out_ready = 1'b0;
    send_frame(1, 12, 1'b0, 2'd0);
    @(negedge clk);
    chk(overflow == 1'b1, "R9 overflow set", 32'(overflow), 32'h1);
    chk(out_valid == 1'b1, "R9 word held", 32'(out_valid), 32'h1);
    chk(out_data == exp_d[0], "R9 first word kept", out_data, exp_d[0]);
    #1 out_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 1'b0, "R9 later words dropped", 32'(out_valid), 32'h0);
    chk(overflow == 1'b1, "R9 overflow sticky", 32'(overflow), 32'h1);
    mon_en = 1;

    finish_up();
  end
endmodule